// File: doc/BRIEF.md
# Two-Way MRU Way Predictor with Serial Tag Probing

This block steers lookups into a two-way set-associative cache whose tag store can return the tag of only one way per cycle. A compact table of one-bit entries remembers which way of each set was used most recently. On each access the block probes that way first, and on that first probe the cache fetches only a slice of the data from the probed way. If the tag compare reports a miss, the block probes the other way on the following cycle.

The table has fewer entries than the cache has sets. It is addressed by the low bits of the set index, so sets that agree in those bits share one entry. This aliasing costs prediction accuracy and never affects correctness. When both probes miss, the block reports a miss and waits for the external refill logic to report which way it filled. It then records that way as the most recently used.

Top module: `wp_way_predictor`

## Requirements
- R1: After reset every table entry names way 0, so the first probe of any set goes to way 0, and `req_ready` is high.
- R2: An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `probe_valid` is 1, `probe_first` is 1, and `probe_way` equals the table entry at index `req_set[PRED_W-1:0]`.
- R3: If `tag_hit` is 1 during the first probe, then in that same cycle `resp_valid`=1, `resp_hit`=1, `resp_slow`=0 and `resp_way`=`probe_way`.
- R4: If `tag_hit` is 0 during the first probe, the next cycle has `probe_valid`=1, `probe_first`=0, and `probe_way` set to the other way.
- R5: If `tag_hit` is 1 during the second probe, then in that same cycle `resp_valid`=1, `resp_hit`=1, `resp_slow`=1 and `resp_way` names the second way.
- R6: On any hit, the table entry for the access index is written with the way that hit. The write takes effect for accesses accepted afterwards.
- R7: If the second probe also misses, then in that cycle `resp_valid`=1 and `resp_hit`=0. After that, `req_ready` stays low until the cycle after `refill_done` is seen. The entry is then written with `refill_way`.
- R8: Two set indices that agree in their low `PRED_W` bits share one table entry, so an update made through one of them predicts the other.
- R9: `req_ready` is high only when no access is in flight. A `req_valid` raised while `req_ready` is low is ignored.
- R10: A `refill_done` pulse that arrives while no miss is waiting leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_set | input | SET_W | Set index of the access |
| tag_hit | input | 1 | Tag-compare result for the way probed this cycle |
| refill_done | input | 1 | Refill of a missed line has completed |
| refill_way | input | 1 | Way that was filled by the refill |
| req_ready | output | 1 | Block is idle and accepts an access |
| probe_valid | output | 1 | A tag probe is issued this cycle |
| probe_way | output | 1 | Way to probe |
| probe_first | output | 1 | This is the predicted (first) probe; only a data slice is read |
| resp_valid | output | 1 | Verdict is available this cycle |
| resp_hit | output | 1 | Verdict: 1 hit, 0 miss |
| resp_slow | output | 1 | The hit was found on the second probe |
| resp_way | output | 1 | Way that hit |

## Verification
The hardest condition to reach from the ports is aliasing: two different sets must update and then read the same entry. Random 17-bit indices almost never collide in their low 13 bits. The stimulus therefore includes directed pairs that differ only above bit 12. The random traffic is also confined to a small pool of low indices, so the bench's model of the table keeps meeting entries that earlier accesses, misses and refills have already written. A stray `refill_done` in the idle state is injected on purpose, and the entry it could have changed is then read back through a normal access.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_REFILL = 2'd3
    } wp_state_e;

    function automatic logic other_way(input logic w);
        return ~w;
    endfunction
endpackage

// File: rtl/wp_mru_table.sv
module wp_mru_table #(
    parameter int PRED_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRED_W-1:0] rd_idx,
    output logic              rd_way,
    input  logic              wr_en,
    input  logic [PRED_W-1:0] wr_idx,
    input  logic              wr_way
);
    localparam int ENTRIES = 1 << PRED_W;

    logic [ENTRIES-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) bits_d[wr_idx] = wr_way;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign rd_way = bits_q[rd_idx];
endmodule

// File: rtl/wp_probe_fsm.sv
module wp_probe_fsm
    import wp_pkg::*;
#(
    parameter int PRED_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_take,
    input  logic [PRED_W-1:0] acc_idx,
    input  logic              pred_way,
    input  logic              tag_hit,
    input  logic              refill_done,
    input  logic              refill_way,
    output logic              idle,
    output logic              wr_en,
    output logic [PRED_W-1:0] wr_idx,
    output logic              wr_way,
    output logic              probe_valid,
    output logic              probe_way,
    output logic              probe_first,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_slow,
    output logic              resp_way
);
    typedef struct packed {
        wp_state_e         st;
        logic [PRED_W-1:0] idx;
        logic              way;
    } fsm_s;

    fsm_s r_d, r_q;

    always_comb begin
        r_d         = r_q;
        wr_en       = 1'b0;
        wr_idx      = r_q.idx;
        wr_way      = r_q.way;
        probe_valid = 1'b0;
        probe_way   = r_q.way;
        probe_first = 1'b0;
        resp_valid  = 1'b0;
        resp_hit    = 1'b0;
        resp_slow   = 1'b0;
        resp_way    = r_q.way;
        unique case (r_q.st)
            ST_IDLE: begin
                if (acc_take) begin
                    r_d.st  = ST_FIRST;
                    r_d.idx = acc_idx;
                    r_d.way = pred_way;
                end
            end
            ST_FIRST: begin
                probe_valid = 1'b1;
                probe_first = 1'b1;
                if (tag_hit) begin
                    resp_valid = 1'b1;
                    resp_hit   = 1'b1;
                    wr_en      = 1'b1;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.way = other_way(r_q.way);
                    r_d.st  = ST_SECOND;
                end
            end
            ST_SECOND: begin
                probe_valid = 1'b1;
                resp_valid  = 1'b1;
                if (tag_hit) begin
                    resp_hit  = 1'b1;
                    resp_slow = 1'b1;
                    wr_en     = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.st = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (refill_done) begin
                    wr_en  = 1'b1;
                    wr_way = refill_way;
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, idx: '0, way: 1'b0};
        else        r_q <= r_d;
    end

    assign idle = (r_q.st == ST_IDLE);
endmodule

// File: rtl/wp_way_predictor.sv
module wp_way_predictor #(
    parameter int SET_W  = 17,
    parameter int PRED_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic             tag_hit,
    input  logic             refill_done,
    input  logic             refill_way,
    output logic             req_ready,
    output logic             probe_valid,
    output logic             probe_way,
    output logic             probe_first,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_slow,
    output logic             resp_way
);
    logic [PRED_W-1:0] rd_idx, wr_idx;
    logic              rd_way, wr_en, wr_way, idle;

    assign rd_idx    = req_set[PRED_W-1:0];
    assign req_ready = idle;

    wp_mru_table #(.PRED_W(PRED_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_way(rd_way),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way)
    );

    wp_probe_fsm #(.PRED_W(PRED_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .acc_take(req_valid && idle), .acc_idx(rd_idx), .pred_way(rd_way),
        .tag_hit(tag_hit), .refill_done(refill_done), .refill_way(refill_way),
        .idle(idle), .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way),
        .probe_valid(probe_valid), .probe_way(probe_way), .probe_first(probe_first),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_slow(resp_slow),
        .resp_way(resp_way)
    );
endmodule

// File: rtl/wp_way_predictor_chk.sv
module wp_way_predictor_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic tag_hit,
    input logic req_ready,
    input logic probe_valid,
    input logic probe_way,
    input logic probe_first,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_slow,
    input logic resp_way
);
    assert_accept_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (probe_valid && probe_first));

    assert_fast_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && probe_first && tag_hit) |->
        (resp_valid && resp_hit && !resp_slow && resp_way == probe_way));

    assert_second_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && probe_first && !tag_hit) |=>
        (probe_valid && !probe_first && probe_way != $past(probe_way)));

    assert_slow_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_slow) |-> (resp_hit && probe_valid && !probe_first));

    assert_miss_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |=> !req_ready);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> !req_ready);
endmodule

bind wp_way_predictor wp_way_predictor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tag_hit(tag_hit),
    .req_ready(req_ready), .probe_valid(probe_valid), .probe_way(probe_way),
    .probe_first(probe_first), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_slow(resp_slow), .resp_way(resp_way)
);

// File: tb/wp_way_predictor_tb_top.sv
`timescale 1ns/1ps
module wp_way_predictor_tb_top;
    localparam int SET_W  = 17;
    localparam int PRED_W = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic tag_hit = 1'b0;
    logic refill_done = 1'b0;
    logic refill_way = 1'b0;
    logic req_ready, probe_valid, probe_way, probe_first;
    logic resp_valid, resp_hit, resp_slow, resp_way;

    int checks = 0;
    int errors = 0;
    bit model [1 << PRED_W];

    always #2 clk = ~clk;

    wp_way_predictor #(.SET_W(SET_W), .PRED_W(PRED_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .tag_hit(tag_hit), .refill_done(refill_done), .refill_way(refill_way),
        .req_ready(req_ready), .probe_valid(probe_valid), .probe_way(probe_way),
        .probe_first(probe_first), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_slow(resp_slow), .resp_way(resp_way)
    );

    function automatic int idx_of(input logic [SET_W-1:0] s);
        return int'(s[PRED_W-1:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // resident: 0 = line in way 0, 1 = line in way 1, 2 = line absent
    task automatic access(input logic [SET_W-1:0] s, input int resident,
                          input logic fill_way, input bit poke_busy);
        int  i;
        logic exp_first;
        i = idx_of(s);
        exp_first = model[i];
        @(negedge clk);
        check("R9 ready idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_set   = s;
        @(negedge clk);
        req_valid = poke_busy;
        req_set   = ~s;
        check("R2 probe_valid", int'(probe_valid), 1);
        check("R2 probe_first", int'(probe_first), 1);
        check("R2 predicted way", int'(probe_way), int'(exp_first));
        check("R9 ready busy", int'(req_ready), 0);
        tag_hit = (resident == int'(exp_first));
        #1;
        if (tag_hit) begin
            check("R3 resp_valid", int'(resp_valid), 1);
            check("R3 resp_hit", int'(resp_hit), 1);
            check("R3 resp_slow", int'(resp_slow), 0);
            check("R3 resp_way", int'(resp_way), int'(exp_first));
            model[i] = exp_first;
            @(negedge clk);
            req_valid = 1'b0;
            tag_hit   = 1'b0;
            return;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 second probe", int'(probe_valid), 1);
        check("R4 not first", int'(probe_first), 0);
        check("R4 other way", int'(probe_way), int'(!exp_first));
        tag_hit = (resident == int'(!exp_first));
        #1;
        check("R5/R7 resp_valid", int'(resp_valid), 1);
        if (tag_hit) begin
            check("R5 resp_hit", int'(resp_hit), 1);
            check("R5 resp_slow", int'(resp_slow), 1);
            check("R5 resp_way", int'(resp_way), int'(!exp_first));
            model[i] = !exp_first;
            @(negedge clk);
            tag_hit = 1'b0;
            return;
        end
        check("R7 resp_hit", int'(resp_hit), 0);
        @(negedge clk);
        tag_hit = 1'b0;
        check("R7 wait refill", int'(req_ready), 0);
        @(negedge clk);
        check("R7 still waiting", int'(req_ready), 0);
        refill_done = 1'b1;
        refill_way  = fill_way;
        @(negedge clk);
        refill_done = 1'b0;
        check("R7 ready after refill", int'(req_ready), 1);
        model[i] = fill_way;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0c0d);
        foreach (model[k]) model[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 no probe at reset", int'(probe_valid), 0);

        // R1: untouched high index predicts way 0; way 1 hit is slow
        access(17'h1ffff, 1, 1'b0, 1'b0);
        // R6: the fast hit now goes to way 1
        access(17'h1ffff, 1, 1'b0, 1'b0);
        // R8: alias differing only above bit 12 shares the entry
        access(17'h00005, 1, 1'b0, 1'b0);
        access(17'h02005 | 17'h08000, 1, 1'b0, 1'b0);
        // R7: double miss, refill writes way 1, then predicted way 1
        access(17'h00042, 2, 1'b1, 1'b0);
        access(17'h00042, 1, 1'b0, 1'b0);
        // R9: request raised while busy is ignored
        access(17'h00077, 0, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 ignored request left idle", int'(probe_valid), 0);
        // R10: stray refill in idle does not change entry 0x77 (way 0)
        refill_done = 1'b1;
        refill_way  = 1'b1;
        @(negedge clk);
        refill_done = 1'b0;
        check("R10 stray refill, still idle", int'(req_ready), 1);
        access(17'h00077, 0, 1'b0, 1'b0);

        // random traffic over a small pool of low indices, high bits varied
        for (int n = 0; n < 600; n++) begin
            logic [SET_W-1:0] s;
            s = SET_W'({$urandom_range(15, 0), 13'($urandom_range(31, 0))});
            access(s, int'($urandom_range(2, 0)), 1'($urandom_range(1, 0)),
                   1'($urandom_range(1, 0)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule